// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a small byte-addressed memory. An external master drives it in SPI mode 0. SCK idles low, the master samples on the rising edge and the slave changes SO on the falling edge. The block samples chip select, serial clock and serial data with its own system clock and finds their edges there. Each chip-select frame carries one command: an 8-bit opcode sent MSB first, then a 16-bit address where the command needs one, then data.

Reads stream bytes from the internal RAM and step the address after every byte, across the whole array. Writes collect their bytes in a one-page staging buffer, in which the column index wraps. The buffer is copied into the RAM only when chip select rises on a whole-byte boundary. A write needs a latch that a stand-alone write-enable frame sets. The write-protect unit supplies a lock bit per block, and the block reports its latch and busy state back to that unit.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is low and SO is not driven.
- R2: The opcodes are 0x03 for read, 0x05 for status read, 0x06 for write enable and 0x02 for write, each shifted MSB first. Any other opcode makes the frame produce no output and no change.
- R3: A read returns the byte at the address and then the following bytes one after another. After address DEPTH-1 it continues at 0. Address bits at and above log2(DEPTH) are ignored.
- R4: The status byte has bit 0 set while a write is busy and bit 1 set while the write-enable latch is set. All other bits are 0. The byte repeats for as long as clocking continues.
- R5: A write-enable frame sets the latch only if chip select rises right after its 8th bit. One or more extra clocks cancel it.
- R6: Write data reaches the RAM only if chip select rises after a whole number of data bytes, with at least one data byte. A trailing partial byte drops the whole write.
- R7: Within a write, the address wraps from the last byte of a PAGE-byte page to the first byte of the same page. Later bytes overwrite earlier ones.
- R8: A write sent with the latch clear, or addressed to a block whose `blk_lock` bit is set, leaves the RAM unchanged. Every accepted write opcode clears the latch when its frame ends.
- R9: After a commit, `busy_o` stays high for PROG_CYC cycles. Write-enable and write frames that start while it is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; frames one command |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, MSB first |
| blk_lock | input | NUM_BLK | Per-block write lock from the write-protect unit |
| so | output | 1 | Serial data out (valid when so_oe is high) |
| so_oe | output | 1 | Output enable for the SO pad; low means high impedance |
| wel_o | output | 1 | Write-enable latch state |
| busy_o | output | 1 | Internal write in progress |

## Verification
The hardest states to reach from the pins are frames that end at an awkward moment: a write-enable followed by one extra clock, a write ending a few bits into a byte, and a write-enable issued while a commit is still busy. The bench reaches these with directed frames that stop clocking mid-byte or that start a new command straight after a commit. It then reads the status byte or the memory to show that nothing changed. Page wrap and the read address rolling over at the top of the array come from writes longer than one page and reads started just below the top. Seeded random writes and reads, with random lock patterns, then run against a memory model held in the bench.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_STAT  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;

   typedef enum logic [2:0] {
      ST_SKIP,
      ST_OP,
      ST_ADDR,
      ST_RD,
      ST_STAT,
      ST_WREN,
      ST_WR
   } cmd_st_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic cs_q,
   output logic cs_rise,
   output logic cs_fall,
   output logic sck_rise,
   output logic sck_fall,
   output logic si_q
);
   logic [STAGES:0] cs_p, sck_p;
   logic [STAGES-1:0] si_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p  <= '1;
         sck_p <= '0;
         si_p  <= '0;
      end else begin
         cs_p  <= {cs_p[STAGES-1:0], cs_n};
         sck_p <= {sck_p[STAGES-1:0], sck};
         si_p  <= {si_p[STAGES-2:0], si};
      end
   end

   assign cs_q     = cs_p[STAGES-1];
   assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
   assign cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
   assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
   assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
   assign si_q     = si_p[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/spi_page_stage.sv
module spi_page_stage #(
   parameter int AW       = 8,
   parameter int PAGE     = 32,
   parameter int PROG_CYC = 600,
   localparam int PW = $clog2(PAGE),
   localparam int CW = $clog2(PROG_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          st_we,
   input  logic [PW-1:0] st_off,
   input  logic [7:0]    st_data,
   input  logic          commit,
   input  logic [AW-PW-1:0] page_no,
   output logic          busy,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata
);
   localparam logic [CW-1:0] PAGE_C = CW'(PAGE);
   localparam logic [CW-1:0] LAST_C = CW'(PROG_CYC - 1);

   logic [7:0]      pbuf [PAGE];
   logic [PAGE-1:0] vld;
   logic [CW-1:0]   cnt;
   logic [AW-PW-1:0] page_r;
   logic [PW-1:0]   col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
         vld    <= '0;
         cnt    <= '0;
         busy   <= 1'b0;
         page_r <= '0;
      end else begin
         if (clear) vld <= '0;
         if (st_we) begin
            pbuf[st_off] <= st_data;
            vld[st_off]  <= 1'b1;
         end
         if (commit) begin
            busy   <= 1'b1;
            cnt    <= '0;
            page_r <= page_no;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_C) begin
               busy <= 1'b0;
               vld  <= '0;
            end
         end
      end
   end

   assign col       = cnt[PW-1:0];
   assign ram_we    = busy && (cnt < PAGE_C) && vld[col];
   assign ram_addr  = {page_r, col};
   assign ram_wdata = pbuf[col];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter int PAGE     = 32,
   parameter int NUM_BLK  = 4,
   parameter int PROG_CYC = 600,
   parameter int SYNC     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sck,
   input  logic               si,
   input  logic [NUM_BLK-1:0] blk_lock,
   output logic               so,
   output logic               so_oe,
   output logic               wel_o,
   output logic               busy_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = $clog2(PAGE);
   localparam int BW = $clog2(NUM_BLK);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4 || DEPTH > 65536) begin : g_bad_depth
      $error("DEPTH must be a power of two between 4 and 65536");
   end
   if ((PAGE & (PAGE - 1)) != 0 || PAGE < 2 || PAGE >= DEPTH) begin : g_bad_page
      $error("PAGE must be a power of two, at least 2 and below DEPTH");
   end
   if ((NUM_BLK & (NUM_BLK - 1)) != 0 || NUM_BLK * PAGE > DEPTH) begin : g_bad_blk
      $error("NUM_BLK must be a power of two and blocks must hold whole pages");
   end
   if (PROG_CYC < PAGE || SYNC < 2) begin : g_bad_prog
      $error("PROG_CYC must cover one page and SYNC needs two stages");
   end

   logic cs_q, cs_rise, cs_fall, sck_rise, sck_fall, si_q;
   spi_in_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .cs_q(cs_q), .cs_rise(cs_rise), .cs_fall(cs_fall),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si_q(si_q)
   );

   cmd_st_t       st;
   logic [2:0]    bit_cnt;
   logic [6:0]    rx_sh;
   logic [7:0]    rx_byte, tx, rdata, status;
   logic [AW-1:0] addr, addr_nxt;
   logic          abyte, is_wr, wr_ok, wr_any, wel, busy, locked;
   logic          st_we, clr, commit;
   logic [PW-1:0] st_off;
   logic [7:0]    st_data;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;

   assign rx_byte = {rx_sh, si_q};
   assign status  = {6'b0, wel, busy};

   if (AW > 8) begin : g_addr_wide
      assign addr_nxt = {addr[AW-9:0], rx_byte};
   end else begin : g_addr_narrow
      assign addr_nxt = rx_byte[AW-1:0];
   end

   if (NUM_BLK > 1) begin : g_lock_multi
      logic [BW-1:0] blk_idx;
      assign blk_idx = addr_nxt[AW-1 -: BW];
      assign locked  = blk_lock[blk_idx];
   end else begin : g_lock_single
      assign locked = blk_lock[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_SKIP; bit_cnt <= '0; rx_sh <= '0; tx <= '0;
         addr <= '0; abyte <= 1'b0; is_wr <= 1'b0; wr_ok <= 1'b0;
         wr_any <= 1'b0; wel <= 1'b0; so_oe <= 1'b0;
         st_we <= 1'b0; clr <= 1'b0; commit <= 1'b0;
         st_off <= '0; st_data <= '0;
      end else begin
         st_we  <= 1'b0;
         clr    <= 1'b0;
         commit <= 1'b0;
         if (cs_fall) begin
            st <= ST_OP; bit_cnt <= '0; abyte <= 1'b0;
            wr_any <= 1'b0; is_wr <= 1'b0; so_oe <= 1'b0;
         end else if (cs_rise) begin
            so_oe <= 1'b0;
            st    <= ST_SKIP;
            is_wr <= 1'b0;
            if (st == ST_WREN) wel <= 1'b1;
            if (is_wr) wel <= 1'b0;
            if (st == ST_WR && bit_cnt == 3'd0 && wr_any && wr_ok) commit <= 1'b1;
         end else if (!cs_q) begin
            if (sck_rise) begin
               rx_sh   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 1'b1;
               if (st == ST_WREN) st <= ST_SKIP;
               if (bit_cnt == 3'd7) begin
                  unique case (st)
                     ST_OP: begin
                        if (rx_byte == OP_READ) st <= ST_ADDR;
                        else if (rx_byte == OP_STAT) st <= ST_STAT;
                        else if (rx_byte == OP_WREN && !busy) st <= ST_WREN;
                        else if (rx_byte == OP_WRITE && !busy) begin
                           st    <= ST_ADDR;
                           is_wr <= 1'b1;
                        end else st <= ST_SKIP;
                     end
                     ST_ADDR: begin
                        addr  <= addr_nxt;
                        abyte <= 1'b1;
                        if (abyte) begin
                           st    <= is_wr ? ST_WR : ST_RD;
                           wr_ok <= wel && !locked;
                           clr   <= is_wr;
                        end
                     end
                     ST_WR: begin
                        st_we   <= 1'b1;
                        st_off  <= addr[PW-1:0];
                        st_data <= rx_byte;
                        addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
                        wr_any  <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end else if (sck_fall && (st == ST_RD || st == ST_STAT)) begin
               if (bit_cnt == 3'd0) begin
                  tx    <= (st == ST_RD) ? rdata : status;
                  so_oe <= 1'b1;
                  if (st == ST_RD) addr <= addr + 1'b1;
               end else begin
                  tx <= {tx[6:0], 1'b0};
               end
            end
         end
      end
   end

   spi_page_stage #(.AW(AW), .PAGE(PAGE), .PROG_CYC(PROG_CYC)) u_stage (
      .clk(clk), .rst_n(rst_n), .clear(clr), .st_we(st_we), .st_off(st_off),
      .st_data(st_data), .commit(commit), .page_no(addr[AW-1:PW]),
      .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   spi_mem_array #(.DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_addr),
      .wdata(ram_wdata), .raddr(addr), .rdata(rdata)
   );

   assign so     = tx[7];
   assign wel_o  = wel;
   assign busy_o = busy;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
   import spi_mem_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    cs_q,
   input logic    sck_fall,
   input logic    so,
   input logic    so_oe,
   input logic    wel,
   input logic    busy,
   input logic    commit,
   input cmd_st_t st
);
   p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q && $past(cs_q) |-> !so_oe);

   p_so_falls_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe && $past(so_oe) && !$past(sck_fall) |-> $stable(so));

   p_wel_from_wren_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(st == ST_WREN));

   p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);

   p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit);
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sck_fall(sck_fall), .so(so),
   .so_oe(so_oe), .wel(wel), .busy(busy), .commit(commit), .st(st)
);

// File: tb/spi_mem_slave_test.sv
`timescale 1ns/1ps
module spi_mem_slave_test;
   localparam int DEPTH = 256, PAGE = 32, NUM_BLK = 4, PROG = 600, HALF = 8;

   logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
   logic [NUM_BLK-1:0] lk = '0;
   logic so, so_oe, wel_o, busy_o;
   int n_run = 0, n_fail = 0;
   logic oe_seen;
   logic [7:0] exp_mem [DEPTH];
   logic [7:0] wdat [64];
   logic wel_m;

   always #5 clk = ~clk;

   spi_mem_slave #(.DEPTH(DEPTH), .PAGE(PAGE), .NUM_BLK(NUM_BLK), .PROG_CYC(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .blk_lock(lk),
      .so(so), .so_oe(so_oe), .wel_o(wel_o), .busy_o(busy_o));

   task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = 'x;
      for (int i = 0; i < n; i++) begin
         si = tx[7-i];
         wait_clks(HALF);
         if (so_oe) begin oe_seen = 1; rx[7-i] = so; end
         sck = 1;
         wait_clks(HALF);
         sck = 0;
      end
   endtask

   task automatic cs_begin();
      oe_seen = 0; cs_n = 0; wait_clks(HALF);
   endtask

   task automatic cs_end();
      wait_clks(HALF); cs_n = 1; wait_clks(8);
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] d;
      spi_bits(b, 8, d);
   endtask

   task automatic rd_status(output logic [7:0] s);
      cs_begin(); send(8'h05); spi_bits(8'h00, 8, s); cs_end();
   endtask

   task automatic do_wren(input int extra);
      logic [7:0] d;
      cs_begin(); send(8'h06);
      if (extra > 0) spi_bits(8'h00, extra, d);
      cs_end();
      if (extra == 0 && !busy_o) wel_m = 1;
   endtask

   task automatic do_write(input logic [15:0] a, input int len, input int extra);
      logic [7:0] d;
      logic [7:0] stg [PAGE];
      logic [PAGE-1:0] v;
      int base;
      cs_begin(); send(8'h02); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < len; i++) send(wdat[i]);
      if (extra > 0) spi_bits(8'hA5, extra, d);
      cs_end();
      v = '0;
      base = int'(a[7:0]) & ~(PAGE - 1);
      for (int i = 0; i < len; i++) begin
         stg[(int'(a[4:0]) + i) % PAGE] = wdat[i];
         v[(int'(a[4:0]) + i) % PAGE] = 1;
      end
      if (wel_m && !lk[a[7:6]] && extra == 0 && len > 0)
         for (int j = 0; j < PAGE; j++) if (v[j]) exp_mem[base + j] = stg[j];
      wel_m = 0;
      wait_clks(PROG + 20);
   endtask

   task automatic do_read(input logic [15:0] a, input int len, input string req);
      logic [7:0] d;
      cs_begin(); send(8'h03); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < len; i++) begin
         spi_bits(8'h00, 8, d);
         chk(d === exp_mem[(int'(a[7:0]) + i) % DEPTH], req, {8'h0, d}, {8'h0, exp_mem[(int'(a[7:0]) + i) % DEPTH]});
      end
      cs_end();
      chk(so_oe === 1'b0, "R1 oe after read", {15'h0, so_oe}, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] s, s2;
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
      wel_m = 0;
      wait_clks(4); rst_n = 1; wait_clks(4);

      // R1 reset state
      chk(so_oe === 1'b0, "R1 reset oe", {15'h0, so_oe}, 16'h0);
      rd_status(s);
      chk(s === 8'h00, "R4 reset status", {8'h0, s}, 16'h0);

      // R2 unknown opcode: no output
      cs_begin(); send(8'hAA); spi_bits(8'h00, 8, s); cs_end();
      chk(oe_seen === 1'b0, "R2 unknown opcode", {15'h0, oe_seen}, 16'h0);

      // R5 wren then status shows latch; R4 repeat
      do_wren(0);
      cs_begin(); send(8'h05); spi_bits(8'h00, 8, s); spi_bits(8'h00, 8, s2); cs_end();
      chk(s === 8'h02, "R5 wren sets latch", {8'h0, s}, 16'h02);
      chk(s2 === 8'h02, "R4 status repeats", {8'h0, s2}, 16'h02);

      // R8 write clears latch; write without latch dropped
      for (int i = 0; i < 64; i++) wdat[i] = 8'(i + 8'h30);
      do_write(16'h0010, 4, 0);
      rd_status(s);
      chk(s === 8'h00, "R8 latch cleared by write", {8'h0, s}, 16'h0);
      do_read(16'h0010, 4, "R6 committed write");
      for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
      do_write(16'h0010, 4, 0);
      do_read(16'h0010, 4, "R8 no latch drop");

      // R5 wren with an extra clock is cancelled
      do_wren(1);
      rd_status(s);
      chk(s === 8'h00, "R5 extra clock cancels", {8'h0, s}, 16'h0);

      // R6 partial trailing byte drops write
      do_wren(0);
      do_write(16'h0020, 3, 3);
      do_read(16'h0020, 3, "R6 partial byte drop");

      // R7 page wrap and overwrite
      do_wren(0);
      for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
      do_write(16'h005E, 5, 0);
      do_read(16'h0040, 3, "R7 wrap to page start");
      do_read(16'h005E, 2, "R7 page end bytes");
      do_wren(0);
      for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
      do_write(16'h0060, 34, 0);
      do_read(16'h0060, 32, "R7 overwrite after wrap");

      // R8 locked block
      lk = 4'b0010;
      do_wren(0);
      for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
      do_write(16'h0050, 4, 0);
      do_read(16'h0050, 4, "R8 locked block");
      lk = '0;

      // R3 rollover at top and high address bits ignored
      do_wren(0);
      do_write(16'h00FC, 4, 0);
      do_read(16'h00FE, 4, "R3 rollover");
      do_read(16'hAB10, 4, "R3 high bits ignored");

      // R9 busy visible, wren during busy ignored
      do_wren(0);
      cs_begin(); send(8'h02); send(8'h00); send(8'h90); send(8'h5A); cs_end();
      exp_mem[8'h90] = 8'h5A; wel_m = 0;
      rd_status(s);
      chk(s === 8'h01, "R9 busy in status", {8'h0, s}, 16'h01);
      do_wren(0);
      wait_clks(PROG + 20);
      rd_status(s);
      chk(s === 8'h00, "R9 wren ignored while busy", {8'h0, s}, 16'h0);
      wel_m = 0;
      do_read(16'h0090, 1, "R9 busy write landed");

      // random mix
      for (int t = 0; t < 30; t++) begin
         logic [15:0] a;
         int len;
         a = 16'($urandom);
         if ($urandom_range(0, 1) == 0) begin
            lk = 4'($urandom);
            if ($urandom_range(0, 4) != 0) do_wren(0);
            len = $urandom_range(1, 40);
            for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
            do_write(a, len, 0);
         end else begin
            len = $urandom_range(1, 6);
            do_read(a, len, "R3 random read");
         end
      end
      lk = '0;
      for (int p = 0; p < DEPTH; p += 64) do_read(16'(p), 64, "R6 final sweep");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule